// File: doc/BRIEF.md
# Command Ring Consumer

This block drains a circular queue of 32-bit command words that software fills in a shared, word-addressed memory. The block reaches that memory through one synchronous RAM port with a read latency of one cycle. The queue's own bookkeeping sits in its first four words, and the block reads all four again on every run. Word 0 is the lower bound (MIN). Word 1 is the upper bound (MAX). Word 2 is the producer position (NEXT). Word 3 is the consumer position (STOP). All four are byte offsets.

A one-cycle `start` pulse begins a run. The block first checks that the bookkeeping is sane and computes how many bytes are pending. It then parses commands one at a time. Three drawing commands are handed downstream on a valid/ready port together with their arguments. Two further known opcodes are consumed and dropped. After each complete command, the consumer position is stored back to word 3. If a command is cut short or its opcode is not recognised, the consumer position returns to where that command began and the run ends. A single-cycle `done` pulse marks the end of every run.

Top module: `cmd_ring_consumer`

## Requirements
- R1: Every run that is allowed to proceed first reads words 0, 1, 2 and 3, in that order, as MIN, MAX, NEXT and STOP.
- R2: When `enable_in` or `cfg_done` is low at `start`, the run ends with `done` and makes no memory access.
- R3: The queue counts as empty, so that no command is issued and nothing is written, when any of the following holds: a pointer has either of its two low bits set; MIN is below 16; MAX is above the buffer size 0x10000; MIN, NEXT or STOP is at or above 0x10000; MAX is below MIN + 10240.
- R4: Pending bytes equal NEXT − STOP. When NEXT is below STOP, MAX − MIN is added. Zero pending bytes means an empty queue.
- R5: Opcode 1 carries 4 argument words and is issued with `cmd_kind`=1. Opcode 2 carries 5 and is issued with `cmd_kind`=2. Opcode 3 carries 6 and is issued with `cmd_kind`=3. Argument i sits at `cmd_args[32*i+31:32*i]` in the order read, and the unused slots are zero.
- R6: Each word read moves STOP on by 4. When it reaches MAX it wraps to MIN. After every complete command, STOP is written to word 3.
- R7: When fewer argument words are pending than the opcode needs, STOP is written back to word 3 as the offset of that opcode, no command is issued and the run ends.
- R8: Any opcode other than 1, 2, 3, 13 and 14 is handled like R7, including opcode 0.
- R9: Opcode 13 (6 words) and opcode 14 (7 words) are consumed without issuing a command. Parsing then continues.
- R10: A run completes at most MAX_CMDS commands. The next run resumes at the stored STOP.
- R11: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_kind` and `cmd_args` hold steady.
- R12: `done` is low after reset and goes high for exactly one cycle per run, at its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle) |
| enable_in | input | 1 | Queue mode enabled |
| cfg_done | input | 1 | Queue memory configured |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 14 | Read word address |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | 14 | Write word address (always word 3) |
| mem_wr_data | output | 32 | Write data (STOP offset) |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_kind | output | 2 | 1 update, 2 fill, 3 copy |
| cmd_args | output | 192 | Six 32-bit argument slots |
| done | output | 1 | End-of-run pulse |

## Verification
A wrong remaining-byte count or a wrong STOP register shows up in word 3 when the run ends. It can show as a word-3 value off by whole commands, as a rewind landing on the wrong opcode, or as a wrap that misses MIN. Any of these is visible within the same run. A slip in the argument index shifts every field of the next issued command, so the first accepted handshake exposes it. Tests where the header is corrupt or the queue is empty must produce exactly four reads, no write and no command. An early exit from the header check, or a stray write-back, therefore shows in the port-level counts.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
    localparam int WORD_W    = 32;
    localparam int ARG_MAX   = 6;
    localparam int HDR_BYTES = 16;
    localparam int STOP_WORD = 3;

    localparam logic [WORD_W-1:0] OP_UPDATE = 32'd1;
    localparam logic [WORD_W-1:0] OP_FILL   = 32'd2;
    localparam logic [WORD_W-1:0] OP_COPY   = 32'd3;
    localparam logic [WORD_W-1:0] OP_SKIP6  = 32'd13;
    localparam logic [WORD_W-1:0] OP_SKIP7  = 32'd14;

    typedef enum logic [1:0] {
        K_NONE   = 2'd0,
        K_UPDATE = 2'd1,
        K_FILL   = 2'd2,
        K_COPY   = 2'd3
    } cmd_kind_e;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR, S_CHK, S_OPC, S_ARG, S_EMIT, S_WB, S_RWD, S_DONE
    } state_e;

    typedef struct packed {
        logic      known;
        cmd_kind_e kind;
        logic [2:0] argc;
    } op_info_t;
endpackage

// File: rtl/cmd_ring_op_decode.sv
module cmd_ring_op_decode
    import cmd_ring_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    output op_info_t          info
);
    always_comb begin
        info = '0;
        case (op)
            OP_UPDATE: info = '{known: 1'b1, kind: K_UPDATE, argc: 3'd4};
            OP_FILL:   info = '{known: 1'b1, kind: K_FILL,   argc: 3'd5};
            OP_COPY:   info = '{known: 1'b1, kind: K_COPY,   argc: 3'd6};
            OP_SKIP6:  info = '{known: 1'b1, kind: K_NONE,   argc: 3'd6};
            OP_SKIP7:  info = '{known: 1'b1, kind: K_NONE,   argc: 3'd7};
            default:   info = '0;
        endcase
    end
endmodule

// File: rtl/cmd_ring_ptr_check.sv
module cmd_ring_ptr_check
    import cmd_ring_pkg::*;
#(
    parameter int BUF_BYTES = 65536,
    parameter int MIN_GAP   = 10240
) (
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    input  logic [WORD_W-1:0] prod,
    input  logic [WORD_W-1:0] cons,
    output logic              ok,
    output logic [WORD_W-1:0] avail
);
    localparam logic [WORD_W-1:0] BUF_LIM = WORD_W'(BUF_BYTES);
    localparam logic [WORD_W-1:0] GAP     = WORD_W'(MIN_GAP);
    localparam logic [WORD_W-1:0] LO_MIN  = WORD_W'(HDR_BYTES);

    logic misaligned;
    logic in_range;

    always_comb begin
        misaligned = |((lo | hi | prod | cons) & 32'd3);
        in_range   = (lo >= LO_MIN) && (hi <= BUF_LIM) && (lo < BUF_LIM)
                   && (cons < BUF_LIM) && (prod < BUF_LIM)
                   && (hi >= lo + GAP);
        ok         = !misaligned && in_range;
        if (prod >= cons) avail = prod - cons;
        else              avail = prod - cons + (hi - lo);
    end
endmodule

// File: rtl/cmd_ring_stop_adv.sv
module cmd_ring_stop_adv
    import cmd_ring_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    output logic [WORD_W-1:0] nxt
);
    logic [WORD_W-1:0] inc;
    always_comb begin
        inc = cur + 32'd4;
        nxt = (inc >= hi) ? lo : inc;
    end
endmodule

// File: rtl/cmd_ring_consumer.sv
module cmd_ring_consumer
    import cmd_ring_pkg::*;
#(
    parameter int BUF_BYTES = 65536,
    parameter int MIN_GAP   = 10240,
    parameter int MAX_CMDS  = 1024,
    localparam int ADDR_W   = $clog2(BUF_BYTES / 4)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      enable_in,
    input  logic                      cfg_done,
    output logic                      mem_rd_en,
    output logic [ADDR_W-1:0]         mem_rd_addr,
    input  logic [WORD_W-1:0]         mem_rd_data,
    output logic                      mem_wr_en,
    output logic [ADDR_W-1:0]         mem_wr_addr,
    output logic [WORD_W-1:0]         mem_wr_data,
    output logic                      cmd_valid,
    input  logic                      cmd_ready,
    output logic [1:0]                cmd_kind,
    output logic [ARG_MAX*WORD_W-1:0] cmd_args,
    output logic                      done
);
    localparam int CNT_W = $clog2(MAX_CMDS + 1);

    state_e            state_q;
    logic              pend_q;
    logic [1:0]        hdr_idx_q;
    logic [WORD_W-1:0] lo_q, hi_q, prod_q, stop_q, cmd_start_q, rem_q;
    logic [CNT_W-1:0]  cnt_q;
    cmd_kind_e         kind_q;
    logic [2:0]        argc_q;
    logic [2:0]        arg_idx_q;
    logic [WORD_W-1:0] args_q [ARG_MAX];

    logic              ptr_ok;
    logic [WORD_W-1:0] avail;
    logic [WORD_W-1:0] stop_nx;
    op_info_t          op_info;

    cmd_ring_ptr_check #(.BUF_BYTES(BUF_BYTES), .MIN_GAP(MIN_GAP)) u_chk (
        .lo(lo_q), .hi(hi_q), .prod(prod_q), .cons(stop_q),
        .ok(ptr_ok), .avail(avail)
    );

    cmd_ring_stop_adv u_adv (.cur(stop_q), .lo(lo_q), .hi(hi_q), .nxt(stop_nx));

    cmd_ring_op_decode u_dec (.op(mem_rd_data), .info(op_info));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            pend_q      <= 1'b0;
            hdr_idx_q   <= '0;
            lo_q        <= '0;
            hi_q        <= '0;
            prod_q      <= '0;
            stop_q      <= '0;
            cmd_start_q <= '0;
            rem_q       <= '0;
            cnt_q       <= '0;
            kind_q      <= K_NONE;
            argc_q      <= '0;
            arg_idx_q   <= '0;
            for (int i = 0; i < ARG_MAX; i++) args_q[i] <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    cnt_q     <= '0;
                    hdr_idx_q <= '0;
                    pend_q    <= 1'b0;
                    state_q   <= (enable_in && cfg_done) ? S_HDR : S_DONE;
                end
                S_HDR: if (!pend_q) begin
                    pend_q <= 1'b1;
                end else begin
                    pend_q <= 1'b0;
                    case (hdr_idx_q)
                        2'd0:    lo_q   <= mem_rd_data;
                        2'd1:    hi_q   <= mem_rd_data;
                        2'd2:    prod_q <= mem_rd_data;
                        default: stop_q <= mem_rd_data;
                    endcase
                    hdr_idx_q <= hdr_idx_q + 2'd1;
                    if (hdr_idx_q == 2'd3) state_q <= S_CHK;
                end
                S_CHK: begin
                    rem_q   <= avail;
                    state_q <= (ptr_ok && avail != '0) ? S_OPC : S_DONE;
                end
                S_OPC: if (!pend_q) begin
                    pend_q      <= 1'b1;
                    cmd_start_q <= stop_q;
                end else begin
                    pend_q    <= 1'b0;
                    stop_q    <= stop_nx;
                    rem_q     <= rem_q - 32'd4;
                    kind_q    <= op_info.kind;
                    argc_q    <= op_info.argc;
                    arg_idx_q <= '0;
                    for (int i = 0; i < ARG_MAX; i++) args_q[i] <= '0;
                    if (!op_info.known ||
                        (rem_q - 32'd4) < {27'd0, op_info.argc, 2'b00})
                        state_q <= S_RWD;
                    else
                        state_q <= S_ARG;
                end
                S_ARG: if (!pend_q) begin
                    pend_q <= 1'b1;
                end else begin
                    pend_q <= 1'b0;
                    stop_q <= stop_nx;
                    rem_q  <= rem_q - 32'd4;
                    if (kind_q != K_NONE && int'(arg_idx_q) < ARG_MAX)
                        args_q[arg_idx_q] <= mem_rd_data;
                    arg_idx_q <= arg_idx_q + 3'd1;
                    if (arg_idx_q == argc_q - 3'd1)
                        state_q <= (kind_q != K_NONE) ? S_EMIT : S_WB;
                end
                S_EMIT: if (cmd_ready) state_q <= S_WB;
                S_WB: begin
                    if (rem_q == '0 || cnt_q == CNT_W'(MAX_CMDS - 1)) begin
                        state_q <= S_DONE;
                    end else begin
                        cnt_q   <= cnt_q + 1'b1;
                        state_q <= S_OPC;
                    end
                end
                S_RWD: begin
                    stop_q  <= cmd_start_q;
                    state_q <= S_DONE;
                end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd_en   = !pend_q && (state_q == S_HDR || state_q == S_OPC || state_q == S_ARG);
        mem_rd_addr = (state_q == S_HDR) ? ADDR_W'(hdr_idx_q) : stop_q[ADDR_W+1:2];
        mem_wr_en   = (state_q == S_WB) || (state_q == S_RWD);
        mem_wr_addr = ADDR_W'(STOP_WORD);
        mem_wr_data = (state_q == S_RWD) ? cmd_start_q : stop_q;
        cmd_valid   = (state_q == S_EMIT);
        cmd_kind    = kind_q;
        done        = (state_q == S_DONE);
    end

    for (genvar g = 0; g < ARG_MAX; g++) begin : g_pack
        assign cmd_args[g*WORD_W +: WORD_W] = args_q[g];
    end

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_args) && $stable(cmd_kind)))
        else $error("R11 command changed while stalled");

    assert_wb_word_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wr_addr == ADDR_W'(STOP_WORD) && mem_wr_data[1:0] == 2'b00))
        else $error("R6 write-back target or alignment wrong");

    assert_port_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en))
        else $error("R1 read and write in one cycle");

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("R12 done longer than one cycle");

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && start && !(enable_in && cfg_done)) |=> (done && !mem_rd_en))
        else $error("R2 gated run accessed memory");

    assert_cmd_limit_R10: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < MAX_CMDS)
        else $error("R10 command count overran");
endmodule

// File: tb/cmd_ring_consumer_tb_top.sv
module cmd_ring_consumer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIM  = 4;
    localparam int RMIN = 16;
    localparam int RMAX = 16 + 10240;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         enable_in = 1'b1;
    logic         cfg_done = 1'b1;
    logic         mem_rd_en, mem_wr_en;
    logic [13:0]  mem_rd_addr, mem_wr_addr;
    logic [31:0]  mem_rd_data, mem_wr_data;
    logic         cmd_valid, cmd_ready, done;
    logic [1:0]   cmd_kind;
    logic [191:0] cmd_args;

    logic [31:0]  mem [0:4095];
    logic         tb_we = 1'b0;
    logic [11:0]  tb_wa = '0;
    logic [31:0]  tb_wd = '0;
    logic         bp_mode = 1'b0;
    logic [1:0]   rdy_ctr = '0;

    int total = 0;
    int bad = 0;

    cmd_ring_consumer #(.MAX_CMDS(LIM)) dut_i (
        .clk(clk), .rst(rst), .start(start), .enable_in(enable_in), .cfg_done(cfg_done),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_args(cmd_args), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];
        if (mem_wr_en) mem[mem_wr_addr[11:0]] <= mem_wr_data;
        if (tb_we)     mem[tb_wa] <= tb_wd;
        rdy_ctr <= rdy_ctr + 2'd1;
    end
    assign cmd_ready = bp_mode ? (rdy_ctr == 2'd3) : 1'b1;

    int rd_cnt, wr_cnt, done_cnt, n_cmd, hold_err;
    logic [1:0]   rec_kind [0:15];
    logic [191:0] rec_args [0:15];
    logic         prev_stall;
    logic [191:0] prev_args;
    logic [1:0]   prev_kind;

    always @(negedge clk) begin
        if (start) begin
            rd_cnt = 0; wr_cnt = 0; done_cnt = 0; n_cmd = 0; hold_err = 0;
            prev_stall = 1'b0;
        end else begin
            if (mem_rd_en) rd_cnt++;
            if (mem_wr_en) wr_cnt++;
            if (done) done_cnt++;
            if (prev_stall && (!cmd_valid || cmd_args != prev_args || cmd_kind != prev_kind))
                hold_err++;
            if (cmd_valid && cmd_ready && n_cmd < 16) begin
                rec_kind[n_cmd] = cmd_kind;
                rec_args[n_cmd] = cmd_args;
                n_cmd++;
            end
            prev_stall = cmd_valid && !cmd_ready;
            prev_args  = cmd_args;
            prev_kind  = cmd_kind;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int byte_off, input logic [31:0] val);
        @(posedge clk); #1;
        tb_we = 1'b1; tb_wa = 12'(byte_off >> 2); tb_wd = val;
        @(posedge clk); #1;
        tb_we = 1'b0;
    endtask

    task automatic set_hdr(input logic [31:0] lo, hi, prod, cons);
        poke(0, lo); poke(4, hi); poke(8, prod); poke(12, cons);
    endtask

    task automatic put_update(input int off, input logic [31:0] a, b, c, d);
        poke(off, 32'd1); poke(off + 4, a); poke(off + 8, b); poke(off + 12, c); poke(off + 16, d);
    endtask

    task automatic run(input string req);
        @(posedge clk); #1; start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(req, "one done pulse per run", done_cnt, 1);
    endtask

    task automatic chk_arg(input string req, input int idx, input int slot, input logic [31:0] exp);
        chk(req, $sformatf("cmd%0d arg%0d", idx, slot), rec_args[idx][32*slot +: 32], exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R12", "done after reset", {31'd0, done}, 0);
        chk("R11", "valid after reset", {31'd0, cmd_valid}, 0);
        chk("R1", "no read after reset", {31'd0, mem_rd_en}, 0);
        chk("R6", "no write after reset", {31'd0, mem_wr_en}, 0);
    endtask

    task automatic t_gated;
        set_hdr(RMIN, RMAX, 36, 16);
        put_update(16, 1, 2, 3, 4);
        enable_in = 1'b0;
        run("R2");
        chk("R2", "reads while disabled", rd_cnt, 0);
        chk("R2", "cmds while disabled", n_cmd, 0);
        enable_in = 1'b1; cfg_done = 1'b0;
        run("R2");
        chk("R2", "reads without cfg", rd_cnt, 0);
        chk("R2", "writes without cfg", wr_cnt, 0);
        cfg_done = 1'b1;
    endtask

    task automatic load_three;
        set_hdr(RMIN, RMAX, 88, 16);
        put_update(16, 10, 20, 30, 40);
        poke(36, 32'd2); poke(40, 32'hAABBCC); poke(44, 1); poke(48, 2); poke(52, 3); poke(56, 4);
        poke(60, 32'd3);
        for (int k = 0; k < 6; k++) poke(64 + 4*k, 32'(5 + k));
    endtask

    task automatic chk_three(input string req);
        chk(req, "cmd count", n_cmd, 3);
        chk("R5", "kind0", {30'd0, rec_kind[0]}, 1);
        chk_arg("R5", 0, 0, 10); chk_arg("R5", 0, 3, 40);
        chk_arg("R5", 0, 4, 0);  chk_arg("R5", 0, 5, 0);
        chk("R5", "kind1", {30'd0, rec_kind[1]}, 2);
        chk_arg("R5", 1, 0, 32'hAABBCC); chk_arg("R5", 1, 4, 4); chk_arg("R5", 1, 5, 0);
        chk("R5", "kind2", {30'd0, rec_kind[2]}, 3);
        chk_arg("R5", 2, 0, 5); chk_arg("R5", 2, 5, 10);
        chk("R6", "stop written back", mem[3], 88);
    endtask

    task automatic t_basic;
        load_three();
        run("R12");
        chk_three("R5");
        chk("R1", "header plus body reads", rd_cnt, 22);
        chk("R6", "one write per command", wr_cnt, 3);
    endtask

    task automatic t_backpressure;
        load_three();
        bp_mode = 1'b1;
        run("R11");
        bp_mode = 1'b0;
        chk("R11", "stall stability violations", hold_err, 0);
        chk_three("R11");
    endtask

    task automatic t_wrap;
        set_hdr(RMIN, RMAX, RMIN + 12, RMAX - 8);
        poke(RMAX - 8, 32'd1); poke(RMAX - 4, 32'h11);
        poke(16, 32'h22); poke(20, 32'h33); poke(24, 32'h44);
        run("R4");
        chk("R4", "wrapped cmd count", n_cmd, 1);
        chk_arg("R6", 0, 0, 32'h11); chk_arg("R6", 0, 1, 32'h22); chk_arg("R6", 0, 3, 32'h44);
        chk("R6", "stop after wrap", mem[3], RMIN + 12);
    endtask

    task automatic t_incomplete;
        set_hdr(RMIN, RMAX, 52, 16);
        put_update(16, 1, 2, 3, 4);
        poke(36, 32'd2); poke(40, 9); poke(44, 9); poke(48, 9);
        run("R7");
        chk("R7", "cmds before short one", n_cmd, 1);
        chk("R7", "stop rewound to opcode", mem[3], 36);
        chk("R7", "writes", wr_cnt, 2);
    endtask

    task automatic t_unknown(input logic [31:0] op);
        set_hdr(RMIN, RMAX, 60, 16);
        put_update(16, 1, 2, 3, 4);
        poke(36, op);
        run("R8");
        chk("R8", $sformatf("cmds with op %0d", op), n_cmd, 1);
        chk("R8", "stop rewound to bad opcode", mem[3], 36);
    endtask

    task automatic t_skip(input logic [31:0] op, input int words);
        int upd;
        upd = 16 + 4 * (words + 1);
        set_hdr(RMIN, RMAX, upd + 20, 16);
        poke(16, op);
        for (int k = 1; k <= words; k++) poke(16 + 4*k, 32'hDEAD);
        put_update(upd, 7, 8, 9, 6);
        run("R9");
        chk("R9", "only the update issued", n_cmd, 1);
        chk("R9", "kind after skip", {30'd0, rec_kind[0]}, 1);
        chk_arg("R9", 0, 0, 7); chk_arg("R9", 0, 3, 6);
        chk("R9", "stop after skip", mem[3], upd + 20);
    endtask

    task automatic t_limit;
        set_hdr(RMIN, RMAX, 136, 16);
        for (int k = 0; k < 6; k++) put_update(16 + 20*k, 32'(k), 0, 0, 0);
        run("R10");
        chk("R10", "first run count", n_cmd, LIM);
        chk("R10", "first run stop", mem[3], 96);
        run("R10");
        chk("R10", "second run count", n_cmd, 2);
        chk_arg("R10", 0, 0, 4);
        chk("R10", "second run stop", mem[3], 136);
    endtask

    task automatic t_bad(input string what, input logic [31:0] lo, hi, prod, cons);
        set_hdr(lo, hi, prod, cons);
        put_update(16, 1, 2, 3, 4);
        run("R3");
        chk("R3", {what, " cmds"}, n_cmd, 0);
        chk("R3", {what, " writes"}, wr_cnt, 0);
        chk("R1", {what, " header reads"}, rd_cnt, 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_gated();
        t_basic();
        t_backpressure();
        t_wrap();
        t_incomplete();
        t_unknown(32'd9);
        t_unknown(32'd0);
        t_skip(32'd13, 6);
        t_skip(32'd14, 7);
        t_limit();
        t_bad("misaligned next", RMIN, RMAX, 38, 16);
        t_bad("min below 16", 12, 12 + 10240, 36, 16);
        t_bad("max past buffer", RMIN, 32'h10004, 36, 16);
        t_bad("gap too small", RMIN, RMIN + 10236, 36, 16);
        t_bad("stop past buffer", RMIN, RMAX, 36, 32'h10000);
        t_bad("empty R4", RMIN, RMAX, 16, 16);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
        $finish;
    end
endmodule